// File: doc/BRIEF.md
# Segment Table Base-Limit Translator

This block turns a segmented virtual address, given as a segment number and an offset, into a physical address. It does this through a small on-chip table of segment descriptors. Each descriptor has three parts: a present flag, a base address, and a limit that gives the segment size. The segment number picks the descriptor. The offset is checked against that descriptor's limit on every access. When the access is legal, the result is the base plus the offset.

Software loads descriptors through a one-entry-per-cycle write port, for example when it switches to another process. A new descriptor is used from the very next translation. The translate port takes one request per cycle and answers one cycle later. The answer is either a physical address or one of two faults: a bounds fault, or a segment-absent fault. If only one descriptor is in use, the block acts as a plain relocation register pair. For example, a 2K-byte limit at a 6K-byte base maps offsets 0 to 0x7FF onto 0x1800 to 0x1FFF.

Top module: `segTranslator`

## Requirements
- R1: Reset drives rspValid low and clears the present flag of every descriptor, so every translation after reset reports the absent fault until a descriptor is written.
- R2: rspValid is high in the cycle after a cycle with xlReq high, and low after a cycle with xlReq low.
- R3: For a present descriptor with offset < limit, rspPhys equals base plus the zero-extended offset, modulo 2^PA_W, with both fault outputs low.
- R4: For a present descriptor with offset >= limit (limit is OFF_W+1 bits wide, so a limit of 0 faults every offset and 2^OFF_W faults none), rspBoundFault is high and rspPhys is 0.
- R5: Translating through a descriptor whose present flag is clear raises rspAbsentFault only, whatever the offset and limit are, and rspPhys is 0.
- R6: rspBoundFault and rspAbsentFault are never high together.
- R7: A descriptor write is used by translations issued in later cycles. A translation issued in the same cycle as a write to the same index sees the old descriptor.
- R8: Writing a descriptor with wrPresent low makes later translations through that index report the absent fault.
- R9: A write to one index leaves every other descriptor unchanged.
- R10: With a single descriptor of base 0x1800 and limit 0x800, offset 0x7FF maps to 0x1FFF and offset 0x800 raises the bounds fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one descriptor |
| wrSeg | input | SEG_W | Index of the descriptor being written |
| wrPresent | input | 1 | Present flag to store |
| wrBase | input | PA_W | Base address to store |
| wrLimit | input | OFF_W+1 | Segment size to store |
| xlReq | input | 1 | Translation request |
| xlSeg | input | SEG_W | Segment number of the request |
| xlOff | input | OFF_W | Offset of the request |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspPhys | output | PA_W | Physical address, or 0 on a fault |
| rspBoundFault | output | 1 | The offset is outside the segment |
| rspAbsentFault | output | 1 | The selected descriptor is not present |

## Verification
The bench uses the default parameters: SEG_W=3, OFF_W=16 and PA_W=24. With eight descriptors, both the first and the last index can be tested. A 17-bit limit lets one segment cover the whole 64K offset range, and another segment with limit zero rejects every offset. A base just below 2^24 makes the sum wrap past the top of the physical range. The vector table walks these cases. Directed tests then cover the write/translate collision on one index, removing a descriptor, and a second reset.

// File: rtl/segPkg.sv
package segPkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic tableWe;
    logic capture;
  } segStrobes_t;
endpackage

// File: rtl/segCtrl.sv
module segCtrl
  import segPkg::*;
(
  input  logic        wrEn,
  input  logic        xlReq,
  output segStrobes_t strobes
);
  always_comb begin
    strobes.tableWe = wrEn;
    strobes.capture = xlReq;
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  segStrobes_t       strobes,
  input  logic [SEG_W-1:0]  wrSeg,
  input  logic              wrPresent,
  input  logic [PA_W-1:0]   wrBase,
  input  logic [OFF_W:0]    wrLimit,
  input  logic [SEG_W-1:0]  xlSeg,
  input  logic [OFF_W-1:0]  xlOff,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPhys,
  output logic              rspBoundFault,
  output logic              rspAbsentFault
);
  localparam int NUM_SEG = 1 << SEG_W;
  localparam int LIM_W   = OFF_W + 1;
  localparam int PAD_W   = PA_W - OFF_W;

  logic [NUM_SEG-1:0] presentQ;
  logic [PA_W-1:0]    baseQ  [NUM_SEG];
  logic [LIM_W-1:0]   limitQ [NUM_SEG];

  // One register slice per descriptor; each decodes its own index
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_entry
    logic hitWr;
    assign hitWr = strobes.tableWe && (wrSeg == SEG_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        presentQ[i] <= 1'b0;
        baseQ[i]    <= '0;
        limitQ[i]   <= '0;
      end else if (hitWr) begin
        presentQ[i] <= wrPresent;
        baseQ[i]    <= wrBase;
        limitQ[i]   <= wrLimit;
      end
    end
  end

  // Lookup reads the registered table, so a same-cycle write is not seen
  logic             selPresent;
  logic [PA_W-1:0]  selBase;
  logic [LIM_W-1:0] selLimit;
  logic             absentD, boundD;
  logic [PA_W-1:0]  sumD;

  always_comb begin
    selPresent = presentQ[xlSeg];
    selBase    = baseQ[xlSeg];
    selLimit   = limitQ[xlSeg];
    absentD    = !selPresent;
    boundD     = selPresent && ({1'b0, xlOff} >= selLimit);
    sumD       = selBase + {{PAD_W{1'b0}}, xlOff};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid       <= 1'b0;
      rspPhys        <= '0;
      rspBoundFault  <= 1'b0;
      rspAbsentFault <= 1'b0;
    end else begin
      rspValid <= strobes.capture;
      if (strobes.capture) begin
        rspPhys        <= (absentD || boundD) ? '0 : sumD;
        rspBoundFault  <= boundD;
        rspAbsentFault <= absentD;
      end
    end
  end
endmodule

// File: rtl/segTranslator.sv
module segTranslator
  import segPkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 16,
  parameter int PA_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEG_W-1:0]  wrSeg,
  input  logic              wrPresent,
  input  logic [PA_W-1:0]   wrBase,
  input  logic [OFF_W:0]    wrLimit,
  input  logic              xlReq,
  input  logic [SEG_W-1:0]  xlSeg,
  input  logic [OFF_W-1:0]  xlOff,
  output logic              rspValid,
  output logic [PA_W-1:0]   rspPhys,
  output logic              rspBoundFault,
  output logic              rspAbsentFault
);
  segStrobes_t strobes;

  segCtrl ctrl_i (
    .wrEn   (wrEn),
    .xlReq  (xlReq),
    .strobes(strobes)
  );

  segDatapath #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrSeg         (wrSeg),
    .wrPresent     (wrPresent),
    .wrBase        (wrBase),
    .wrLimit       (wrLimit),
    .xlSeg         (xlSeg),
    .xlOff         (xlOff),
    .rspValid      (rspValid),
    .rspPhys       (rspPhys),
    .rspBoundFault (rspBoundFault),
    .rspAbsentFault(rspAbsentFault)
  );
endmodule

// File: rtl/segTranslatorChecker.sv
module segTranslatorChecker #(
  parameter int PA_W = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic            xlReq,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPhys,
  input logic            rspBoundFault,
  input logic            rspAbsentFault
);
  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    xlReq |=> rspValid);
  p_quiet_after_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !xlReq |=> !rspValid);
  p_faults_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspBoundFault, rspAbsentFault}));
  p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspBoundFault || rspAbsentFault)) |-> (rspPhys == '0));
endmodule

bind segTranslator segTranslatorChecker #(.PA_W(PA_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .xlReq         (xlReq),
  .rspValid      (rspValid),
  .rspPhys       (rspPhys),
  .rspBoundFault (rspBoundFault),
  .rspAbsentFault(rspAbsentFault)
);

// File: tb/segTranslator_tb_top.sv
module segTranslator_tb_top;
  localparam int SEG_W = 3;
  localparam int OFF_W = 16;
  localparam int PA_W  = 24;
  localparam int NVEC  = 10;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [SEG_W-1:0] wrSeg = '0;
  logic             wrPresent = 1'b0;
  logic [PA_W-1:0]  wrBase = '0;
  logic [OFF_W:0]   wrLimit = '0;
  logic             xlReq = 1'b0;
  logic [SEG_W-1:0] xlSeg = '0;
  logic [OFF_W-1:0] xlOff = '0;
  logic             rspValid;
  logic [PA_W-1:0]  rspPhys;
  logic             rspBoundFault;
  logic             rspAbsentFault;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  segTranslator #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) dut_i (.*);

  // {seg[3], off[16], phys[24], bound, absent}
  localparam logic [44:0] VEC [NVEC] = '{
    {3'd0, 16'h0000, 24'h001800, 1'b0, 1'b0},
    {3'd0, 16'h07FF, 24'h001FFF, 1'b0, 1'b0},
    {3'd0, 16'h0800, 24'h000000, 1'b1, 1'b0},
    {3'd1, 16'hFFFF, 24'h10FFFF, 1'b0, 1'b0},
    {3'd3, 16'h01FF, 24'h0000FF, 1'b0, 1'b0},
    {3'd3, 16'h0100, 24'h000000, 1'b0, 1'b0},
    {3'd3, 16'h0200, 24'h000000, 1'b1, 1'b0},
    {3'd5, 16'h0000, 24'h000000, 1'b1, 1'b0},
    {3'd2, 16'h0000, 24'h000000, 1'b0, 1'b1},
    {3'd7, 16'hFFFF, 24'h000000, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [SEG_W-1:0] s, input logic p,
                         input logic [PA_W-1:0] b, input logic [OFF_W:0] l);
    @(negedge clk);
    wrEn = 1'b1; wrSeg = s; wrPresent = p; wrBase = b; wrLimit = l;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doXlate(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
    @(negedge clk);
    xlReq = 1'b1; xlSeg = s; xlOff = o;
    @(negedge clk);
    xlReq = 1'b0;
  endtask

  task automatic expectRsp(input string tag, input logic [PA_W-1:0] p,
                           input logic bf, input logic af);
    chk({tag, " valid"}, 32'(rspValid), 32'd1);
    chk({tag, " phys"}, 32'(rspPhys), 32'(p));
    chk({tag, " bound"}, 32'(rspBoundFault), 32'(bf));
    chk({tag, " absent"}, 32'(rspAbsentFault), 32'(af));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid low after reset", 32'(rspValid), 32'd0);
    doXlate(3'd0, 16'h0000);
    expectRsp("R1 absent after reset", 24'h0, 1'b0, 1'b1);
    @(negedge clk);
    chk("R2 valid drops when idle", 32'(rspValid), 32'd0);

    // R10 single descriptor: base 6K, limit 2K
    doWrite(3'd0, 1'b1, 24'h001800, 17'h00800);
    doWrite(3'd1, 1'b1, 24'h100000, 17'h10000);
    doWrite(3'd3, 1'b1, 24'hFFFF00, 17'h00200);
    doWrite(3'd5, 1'b1, 24'h020000, 17'h00000);

    // R3 R4 R5 R10 vector walk
    for (int i = 0; i < NVEC; i++) begin
      doXlate(VEC[i][44:42], VEC[i][41:26]);
      expectRsp($sformatf("R3/R4/R5/R10 vec%0d", i), VEC[i][25:2], VEC[i][1], VEC[i][0]);
    end

    // R2 back-to-back requests stay valid
    @(negedge clk); xlReq = 1'b1; xlSeg = 3'd0; xlOff = 16'h0010;
    @(negedge clk);
    expectRsp("R2 first of pair", 24'h001810, 1'b0, 1'b0);
    xlOff = 16'h0020;
    @(negedge clk); xlReq = 1'b0;
    expectRsp("R2 second of pair", 24'h001820, 1'b0, 1'b0);

    // R7 same-cycle write and translate on index 3 sees the old descriptor
    @(negedge clk);
    wrEn = 1'b1; wrSeg = 3'd3; wrPresent = 1'b1; wrBase = 24'h400000; wrLimit = 17'h00100;
    xlReq = 1'b1; xlSeg = 3'd3; xlOff = 16'h0180;
    @(negedge clk);
    wrEn = 1'b0; xlReq = 1'b0;
    expectRsp("R7 collision old value", 24'h000080, 1'b0, 1'b0);
    doXlate(3'd3, 16'h0080);
    expectRsp("R7 new value after write", 24'h400080, 1'b0, 1'b0);
    doXlate(3'd3, 16'h0180);
    expectRsp("R7 new limit applies", 24'h0, 1'b1, 1'b0);

    // R8 remove descriptor 1; R9 descriptor 0 untouched
    doWrite(3'd1, 1'b0, 24'h100000, 17'h10000);
    doXlate(3'd1, 16'h0000);
    expectRsp("R8 removed descriptor", 24'h0, 1'b0, 1'b1);
    doXlate(3'd0, 16'h07FF);
    expectRsp("R9 neighbour unchanged", 24'h001FFF, 1'b0, 1'b0);

    // R5 absent wins even with offset past a zero limit
    doWrite(3'd6, 1'b0, 24'h000000, 17'h00000);
    doXlate(3'd6, 16'hFFFF);
    expectRsp("R5 absent over bound", 24'h0, 1'b0, 1'b1);

    // R1 second reset clears present flags
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 valid low in second reset", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    doXlate(3'd0, 16'h0000);
    expectRsp("R1 cleared by second reset", 24'h0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule